// File: doc/BRIEF.md
# Opcode-Decoded Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a simple accumulator processor. Each cycle it takes a 32-bit operand fetched from memory and the current accumulator value, and a 4-bit operation code. It drives a combinational result bus and an accumulator write enable. It keeps four status flags in registers: carry, zero, negative and overflow. A single execute strobe marks the cycle in which the operation counts. On that cycle the surrounding datapath loads the result into the accumulator when the write enable is high, and the flags take their new values at the same clock edge.

There is one adder. Every subtraction feeds it the bitwise complement of the memory operand, with the accumulator on the other input. The carry-in comes from the operation: zero, one, or the stored carry flag. Compare and bit test change flags only. Move passes the memory operand through unchanged. The three logical operations work bit by bit. The interface is plain control with no handshake: the block never stalls, and the strobe alone says when an operation takes effect.

Top module: `opalu_core`

## Requirements
- R1: With op_code 0101 (add), result equals acc_opnd + mem_opnd modulo 2^32, using a carry-in of 0.
- R2: Op_codes 0100 (add with carry) and 0000 (subtract with borrow) use the stored carry flag as carry-in. Op_codes 0001 (subtract) and 0011 (compare) use a carry-in of 1.
- R3: Op_codes 0001, 0000 and 0011 add the bitwise complement of mem_opnd to acc_opnd, so subtract yields acc_opnd - mem_opnd.
- R4: With op_code 0010 (move), result equals mem_opnd.
- R5: Op_codes 1000, 1001 and 1010 give the bitwise OR, AND and XOR of the operands. Op_code 1011 (bit test) gives their AND.
- R6: acc_we is 1 only while exec_stb is 1 and op_code is one of 0000, 0001, 0010, 0100, 0101, 1000, 1001, 1010. Compare (0011) and bit test (1011) never raise it.
- R7: On a clock edge with exec_stb high and a listed op_code, flag_z becomes 1 exactly when all 32 result bits are 0, and flag_n becomes result bit 31. This includes logical, move, compare and bit test.
- R8: flag_c loads bit 32 of the 33-bit adder sum only on add, add with carry, subtract and subtract with borrow. Every other operation, compare included, leaves it unchanged.
- R9: On those same four operations, flag_v becomes 1 when both adder inputs share a sign and the sum's bit 31 differs from that sign. Otherwise flag_v is unchanged.
- R10: Op_codes 0110, 0111 and 1100 through 1111 keep acc_we at 0 and leave all four flags unchanged.
- R11: A clock edge with exec_stb low leaves all four flags unchanged.
- R12: While rst_n is low at a clock edge, all four flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| exec_stb | input | 1 | Execute strobe; the operation takes effect this cycle |
| op_code | input | 4 | Operation selector |
| mem_opnd | input | 32 | Operand read from memory |
| acc_opnd | input | 32 | Current accumulator value |
| result | output | 32 | Combinational result bus |
| acc_we | output | 1 | Accumulator load enable for this cycle |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The bound checker checks several rules on every cycle: the flags hold without a strobe or on an unlisted code, carry and overflow hold outside the four add/subtract operations, zero and negative follow the result bus of the previous cycle, move passes the operand through, and the accumulator is never written without a strobe or on compare and bit test. The arithmetic values themselves can only be shown by the bench's directed scenarios. These cover carry chaining through the stored flag, borrow in both directions, signed overflow at both ends of the range, and the clearing of the flags at reset.

// File: rtl/opalu_pkg.sv
package opalu_pkg;

  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_SBC = 4'b0000,
    OP_SUB = 4'b0001,
    OP_MOV = 4'b0010,
    OP_CMP = 4'b0011,
    OP_ADC = 4'b0100,
    OP_ADD = 4'b0101,
    OP_ORA = 4'b1000,
    OP_AND = 4'b1001,
    OP_XOR = 4'b1010,
    OP_BIT = 4'b1011
  } op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_e;

  typedef enum logic [2:0] {
    SRC_SUM  = 3'd0,
    SRC_PASS = 3'd1,
    SRC_OR   = 3'd2,
    SRC_AND  = 3'd3,
    SRC_XOR  = 3'd4
  } src_e;

  typedef struct packed {
    logic known;
    logic inv_mem;
    cin_e cin;
    src_e src;
    logic wr_acc;
    logic arith;
  } ctrl_t;

endpackage

// File: rtl/opalu_decode.sv
module opalu_decode
  import opalu_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  output ctrl_t          ctrl
);

  always_comb begin
    ctrl = '{known: 1'b0, inv_mem: 1'b0, cin: CIN_ZERO,
             src: SRC_SUM, wr_acc: 1'b0, arith: 1'b0};
    case (op_code)
      OP_ADD: begin
        ctrl.known = 1'b1; ctrl.wr_acc = 1'b1; ctrl.arith = 1'b1;
      end
      OP_ADC: begin
        ctrl.known = 1'b1; ctrl.wr_acc = 1'b1; ctrl.arith = 1'b1;
        ctrl.cin = CIN_FLAG;
      end
      OP_SUB: begin
        ctrl.known = 1'b1; ctrl.wr_acc = 1'b1; ctrl.arith = 1'b1;
        ctrl.inv_mem = 1'b1; ctrl.cin = CIN_ONE;
      end
      OP_SBC: begin
        ctrl.known = 1'b1; ctrl.wr_acc = 1'b1; ctrl.arith = 1'b1;
        ctrl.inv_mem = 1'b1; ctrl.cin = CIN_FLAG;
      end
      OP_CMP: begin
        ctrl.known = 1'b1; ctrl.inv_mem = 1'b1; ctrl.cin = CIN_ONE;
      end
      OP_MOV: begin
        ctrl.known = 1'b1; ctrl.wr_acc = 1'b1; ctrl.src = SRC_PASS;
      end
      OP_ORA: begin
        ctrl.known = 1'b1; ctrl.wr_acc = 1'b1; ctrl.src = SRC_OR;
      end
      OP_AND: begin
        ctrl.known = 1'b1; ctrl.wr_acc = 1'b1; ctrl.src = SRC_AND;
      end
      OP_XOR: begin
        ctrl.known = 1'b1; ctrl.wr_acc = 1'b1; ctrl.src = SRC_XOR;
      end
      OP_BIT: begin
        ctrl.known = 1'b1; ctrl.src = SRC_AND;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/opalu_adder.sv
module opalu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam int unsigned MSB = W - 1;

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[W];
    ovf  = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
  end

endmodule

// File: rtl/opalu_logic.sv
module opalu_logic
  import opalu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] mem_v,
  input  logic [W-1:0] acc_v,
  input  src_e         src,
  output logic [W-1:0] res
);

  always_comb begin
    case (src)
      SRC_PASS: res = mem_v;
      SRC_OR:   res = mem_v | acc_v;
      SRC_AND:  res = mem_v & acc_v;
      SRC_XOR:  res = mem_v ^ acc_v;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/opalu_flags.sv
module opalu_flags #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic         upd_cv,
  input  logic [W-1:0] res,
  input  logic         cout,
  input  logic         ovf,
  output logic         c_q,
  output logic         z_q,
  output logic         n_q,
  output logic         v_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
      n_q <= 1'b0;
      v_q <= 1'b0;
    end else if (upd) begin
      z_q <= (res == '0);
      n_q <= res[W-1];
      if (upd_cv) begin
        c_q <= cout;
        v_q <= ovf;
      end
    end
  end

endmodule

// File: rtl/opalu_core.sv
module opalu_core
  import opalu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_stb,
  input  logic [3:0]    op_code,
  input  logic [DW-1:0] mem_opnd,
  input  logic [DW-1:0] acc_opnd,
  output logic [DW-1:0] result,
  output logic          acc_we,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_v
);

  ctrl_t          ctrl;
  logic [DW-1:0]  add_a;
  logic           add_cin;
  logic [DW-1:0]  sum;
  logic           cout;
  logic           ovf;
  logic [DW-1:0]  logic_res;

  opalu_decode u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  always_comb begin
    add_a = ctrl.inv_mem ? ~mem_opnd : mem_opnd;
    case (ctrl.cin)
      CIN_ONE:  add_cin = 1'b1;
      CIN_FLAG: add_cin = flag_c;
      default:  add_cin = 1'b0;
    endcase
  end

  opalu_adder #(.W(DW)) u_add (
    .a    (add_a),
    .b    (acc_opnd),
    .cin  (add_cin),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf)
  );

  opalu_logic #(.W(DW)) u_log (
    .mem_v (mem_opnd),
    .acc_v (acc_opnd),
    .src   (ctrl.src),
    .res   (logic_res)
  );

  always_comb begin
    result = (ctrl.src == SRC_SUM) ? sum : logic_res;
    acc_we = exec_stb & ctrl.known & ctrl.wr_acc;
  end

  opalu_flags #(.W(DW)) u_flg (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (exec_stb & ctrl.known),
    .upd_cv (ctrl.arith),
    .res    (result),
    .cout   (cout),
    .ovf    (ovf),
    .c_q    (flag_c),
    .z_q    (flag_z),
    .n_q    (flag_n),
    .v_q    (flag_v)
  );

endmodule

// File: rtl/opalu_checker.sv
module opalu_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_stb,
  input logic [3:0]    op_code,
  input logic [DW-1:0] mem_opnd,
  input logic [DW-1:0] result,
  input logic          acc_we,
  input logic          flag_c,
  input logic          flag_z,
  input logic          flag_n,
  input logic          flag_v
);

  logic known_op;
  logic arith_op;

  always_comb begin
    known_op = op_code inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100,
                               4'b0101, 4'b1000, 4'b1001, 4'b1010, 4'b1011};
    arith_op = op_code inside {4'b0000, 4'b0001, 4'b0100, 4'b0101};
  end

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_stb |=> $stable({flag_c, flag_z, flag_n, flag_v}));

  a_r10_hold_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && !known_op) |=> $stable({flag_c, flag_z, flag_n, flag_v}));

  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !known_op |-> !acc_we);

  a_r8_cv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && !arith_op) |=> $stable({flag_c, flag_v}));

  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && known_op) |=> (flag_z == ($past(result) == '0)));

  a_r7_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && known_op) |=> (flag_n == $past(result[DW-1])));

  a_r6_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> exec_stb);

  a_r6_cmp_bit_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'b0011 || op_code == 4'b1011) |-> !acc_we);

  a_r4_move: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'b0010) |-> (result == mem_opnd));

endmodule

bind opalu_core opalu_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .exec_stb (exec_stb),
  .op_code  (op_code),
  .mem_opnd (mem_opnd),
  .result   (result),
  .acc_we   (acc_we),
  .flag_c   (flag_c),
  .flag_z   (flag_z),
  .flag_n   (flag_n),
  .flag_v   (flag_v)
);

// File: tb/opalu_core_test.sv
module opalu_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_stb = 1'b0;
  logic [3:0]  op_code = 4'b0000;
  logic [31:0] mem_opnd = '0;
  logic [31:0] acc_opnd = '0;
  logic [31:0] result;
  logic        acc_we;
  logic        flag_c, flag_z, flag_n, flag_v;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench-side flag model
  bit mc = 1'b0, mz = 1'b0, mn = 1'b0, mv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opalu_core uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_stb (exec_stb),
    .op_code  (op_code),
    .mem_opnd (mem_opnd),
    .acc_opnd (acc_opnd),
    .result   (result),
    .acc_we   (acc_we),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .flag_v   (flag_v)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] m,
                        input logic [31:0] a, input bit stb, input string req);
    bit known, arith, wr, inv;
    bit cin;
    logic [31:0] ain, exp_res;
    logic [32:0] s;
    bit ovf;
    string we_req;
    known = op inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hB};
    arith = op inside {4'h0, 4'h1, 4'h4, 4'h5};
    wr    = known && !(op == 4'h3 || op == 4'hB);
    inv   = op inside {4'h0, 4'h1, 4'h3};
    case (op)
      4'h5:       cin = 1'b0;
      4'h1, 4'h3: cin = 1'b1;
      default:    cin = mc;
    endcase
    ain = inv ? ~m : m;
    s   = {1'b0, a} + {1'b0, ain} + {32'd0, cin};
    ovf = (ain[31] == a[31]) && (s[31] != ain[31]);
    case (op)
      4'h2:       exp_res = m;
      4'h8:       exp_res = m | a;
      4'h9, 4'hB: exp_res = m & a;
      4'hA:       exp_res = m ^ a;
      default:    exp_res = s[31:0];
    endcase
    if (!known) we_req = "R10";
    else if (!stb) we_req = "R11";
    else we_req = "R6";

    @(negedge clk);
    op_code = op; mem_opnd = m; acc_opnd = a; exec_stb = stb;
    #1;
    if (known) chk(result === exp_res, req, "result", result, exp_res);
    chk(acc_we === (stb && wr), we_req, "acc_we", {31'd0, acc_we}, {31'd0, stb && wr});

    if (stb && known) begin
      mz = (exp_res == 32'd0);
      mn = exp_res[31];
      if (arith) begin
        mc = s[32];
        mv = ovf;
      end
    end
    @(negedge clk);
    exec_stb = 1'b0;
    chk(flag_z === mz, (known && stb) ? "R7" : we_req, "flag_z", {31'd0, flag_z}, {31'd0, mz});
    chk(flag_n === mn, (known && stb) ? "R7" : we_req, "flag_n", {31'd0, flag_n}, {31'd0, mn});
    chk(flag_c === mc, (arith && stb) ? "R8" : we_req, "flag_c", {31'd0, flag_c}, {31'd0, mc});
    chk(flag_v === mv, (arith && stb) ? "R9" : we_req, "flag_v", {31'd0, flag_v}, {31'd0, mv});
  endtask

  task automatic t_reset();
    // R12: flags clear under reset
    run_op(4'h5, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, "R1");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    mc = 0; mz = 0; mn = 0; mv = 0;
    chk({flag_c, flag_z, flag_n, flag_v} === 4'b0000, "R12", "flags",
        {28'd0, flag_c, flag_z, flag_n, flag_v}, 32'd0);
  endtask

  task automatic t_add();
    run_op(4'h5, 32'd7, 32'd5, 1'b1, "R1");
    run_op(4'h5, 32'd1, 32'hFFFF_FFFF, 1'b1, "R1");
  endtask

  task automatic t_carry_in();
    // carry is 1 from the previous add: R2 add with carry picks it up
    run_op(4'h4, 32'd20, 32'd10, 1'b1, "R2");
    // carry now 0: subtract with borrow
    run_op(4'h0, 32'd3, 32'd10, 1'b1, "R2");
    // carry now 1
    run_op(4'h0, 32'd3, 32'd10, 1'b1, "R2");
  endtask

  task automatic t_subtract();
    run_op(4'h1, 32'd3, 32'd10, 1'b1, "R3");
    run_op(4'h1, 32'd10, 32'd3, 1'b1, "R3");
  endtask

  task automatic t_overflow();
    run_op(4'h5, 32'd1, 32'h7FFF_FFFF, 1'b1, "R9");
    run_op(4'h1, 32'd1, 32'h8000_0000, 1'b1, "R9");
    run_op(4'h5, 32'h8000_0000, 32'h8000_0000, 1'b1, "R9");
  endtask

  task automatic t_compare();
    run_op(4'h3, 32'd5, 32'd5, 1'b1, "R3");
    run_op(4'h3, 32'd9, 32'd5, 1'b1, "R3");
  endtask

  task automatic t_move();
    run_op(4'h2, 32'h8000_0001, 32'h1234_5678, 1'b1, "R4");
    run_op(4'h2, 32'd0, 32'hFFFF_FFFF, 1'b1, "R4");
  endtask

  task automatic t_logic();
    run_op(4'h8, 32'hF0F0_0000, 32'h0F0F_0001, 1'b1, "R5");
    run_op(4'h9, 32'hFF00_FF00, 32'h0FF0_0FF0, 1'b1, "R5");
    run_op(4'hA, 32'hAAAA_5555, 32'hAAAA_5555, 1'b1, "R5");
    run_op(4'hB, 32'h0000_00F0, 32'h0000_000F, 1'b1, "R5");
    run_op(4'hB, 32'h8000_0000, 32'hC000_0000, 1'b1, "R5");
  endtask

  task automatic t_unlisted();
    // set all flags to a known nonzero mix first
    run_op(4'h5, 32'd1, 32'h7FFF_FFFF, 1'b1, "R1");
    for (int k = 0; k < 6; k++) begin
      logic [3:0] code;
      code = (k < 2) ? 4'(6 + k) : 4'(10 + k);
      run_op(code, 32'd0, 32'd0, 1'b1, "R10");
    end
  endtask

  task automatic t_idle();
    run_op(4'h5, 32'd0, 32'd0, 1'b0, "R11");
    run_op(4'h1, 32'd1, 32'h8000_0000, 1'b0, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({flag_c, flag_z, flag_n, flag_v} === 4'b0000, "R12", "flags after reset",
        {28'd0, flag_c, flag_z, flag_n, flag_v}, 32'd0);
    t_add();
    t_carry_in();
    t_subtract();
    t_overflow();
    t_compare();
    t_move();
    t_logic();
    t_unlisted();
    t_idle();
    t_reset();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule